// File: doc/BRIEF.md
# Stalled-Rotor Retry Timer

This block guards a single-phase fan drive against a stalled rotor. While the drive is active it expects a steady stream of rotation edges from the speed-feedback comparator, supplied as a one-cycle strobe. If a whole drive window goes by without an edge, it declares a stall. It then inhibits the bridge for a long rest window, releases the bridge for a short retry window, and keeps repeating that pair. The rest window is roughly ten times the retry window.

A rotation edge during a retry window ends the protection at once. The block then goes back to normal running and emits a one-cycle release strobe, which the surrounding drive uses to launch its start-assist sequence. Dropping the active-mode enable (stand-by) clears any protection and restarts the timing.

Both window lengths are given as a tick count times a shared prescaler ratio. A bench can shrink multi-second intervals to a few dozen clocks without changing the state behaviour. Window length is exactly `PRESCALE * ticks` clock cycles, counted from the edge at which the timer restarted.

Top module: `stall_guard`

## Requirements
- R1: While reset is asserted, and on the first cycles after it, `drive_inhibit`, `prot_active` and `release_pulse` are all 0.
- R2: The stall timer starts from zero on the edge at which `active` is first sampled high. If no edge is sampled in normal running, `prot_active` and `drive_inhibit` rise together after that edge plus `PRESCALE*ON_TICKS - 1` further clock edges.
- R3: A rotation edge sampled in normal running restarts the timer. The next stall is declared `PRESCALE*ON_TICKS` clock edges after the edge that sampled the rotation strobe.
- R4: In the rest window, `drive_inhibit` = 1 and `prot_active` = 1 for exactly `PRESCALE*OFF_TICKS` cycles, and rotation strobes are ignored.
- R5: After the rest window, a retry window follows with `drive_inhibit` = 0 and `prot_active` = 1 for `PRESCALE*ON_TICKS` cycles. Without a rotation strobe, the block returns to the rest window.
- R6: A rotation strobe sampled in a retry window clears `prot_active` on the next cycle. `release_pulse` is high for exactly that one cycle.
- R7: When `active` is sampled low, the block is in normal running at the next cycle with all outputs 0, and its timer is cleared.
- R8: `release_pulse` only follows a retry window, and `drive_inhibit` is never 1 while `prot_active` is 0. Both hold under any mix of strobes and enable drops.
- R9: If a rotation strobe falls on the very cycle at which a window would expire, the strobe takes priority. Normal running stays in normal running, and a retry window releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| active | input | 1 | Drive active-mode enable; low means stand-by |
| fg_edge | input | 1 | One-cycle strobe per rotation-feedback transition |
| drive_inhibit | output | 1 | 1 holds both bridge outputs low |
| prot_active | output | 1 | 1 while stall protection is engaged |
| release_pulse | output | 1 | One-cycle strobe when protection ends on rotation |

## Verification
The bench builds the block with `PRESCALE` = 3, `ON_TICKS` = 4 and `OFF_TICKS` = 40. This gives 12-cycle drive and retry windows and a 120-cycle rest window, still in a ten-to-one ratio. With these values many complete stall, rest, retry and release loops fit into a short run. The prescaler wrap, the tick-counter wrap and the exact expiry cycle are all reached many times. The prescaler value above one also means the expiry edge depends on both counters lining up, not on the tick counter alone.

// File: rtl/stall_pkg.sv
package stall_pkg;

    typedef enum logic [1:0] {
        ST_RUN = 2'd0,
        ST_OFF = 2'd1,
        ST_TRY = 2'd2
    } stall_state_e;

    typedef struct packed {
        stall_state_e state;
        logic         release_strobe;
    } guard_regs_t;

endpackage

// File: rtl/stall_tick.sv
module stall_tick #(
    parameter int PRESCALE = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic en,
    output logic tick
);

    generate
        if (PRESCALE <= 1) begin : g_direct
            // Every enabled cycle is a tick.
            assign tick = en;
        end else begin : g_divide
            localparam int PW = $clog2(PRESCALE);
            localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

            logic [PW-1:0] pre_d, pre_q;

            always_comb begin
                pre_d = pre_q;
                if (restart) begin
                    pre_d = '0;
                end else if (en) begin
                    pre_d = (pre_q == LAST) ? '0 : pre_q + PW'(1);
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pre_q <= '0;
                else        pre_q <= pre_d;
            end

            assign tick = en && (pre_q == LAST);

            p_prescale_in_range_r2: assert property (
                @(posedge clk) disable iff (!rst_n) pre_q <= LAST);
        end
    endgenerate

endmodule

// File: rtl/stall_window.sv
module stall_window #(
    parameter int PRESCALE  = 1000,
    parameter int MAX_TICKS = 6000,
    localparam int TW = $clog2(MAX_TICKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          en,
    input  logic [TW-1:0] limit,
    output logic          expire
);

    logic          tick;
    logic [TW-1:0] tcnt_d, tcnt_q;

    stall_tick #(.PRESCALE(PRESCALE)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .en      (en),
        .tick    (tick)
    );

    assign expire = tick && (tcnt_q == (limit - TW'(1)));

    always_comb begin
        tcnt_d = tcnt_q;
        if (restart) begin
            tcnt_d = '0;
        end else if (tick) begin
            tcnt_d = tcnt_q + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tcnt_q <= '0;
        else        tcnt_q <= tcnt_d;
    end

    // The owner restarts the window on expiry, so the count stays below the limit.
    p_ticks_below_limit_r4: assert property (
        @(posedge clk) disable iff (!rst_n) tcnt_q < limit);

endmodule

// File: rtl/stall_guard.sv
module stall_guard
    import stall_pkg::*;
#(
    parameter int PRESCALE  = 50000,
    parameter int ON_TICKS  = 600,
    parameter int OFF_TICKS = 6000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic fg_edge,
    output logic drive_inhibit,
    output logic prot_active,
    output logic release_pulse
);

    localparam int MAX_TICKS = (OFF_TICKS > ON_TICKS) ? OFF_TICKS : ON_TICKS;
    localparam int TW        = $clog2(MAX_TICKS + 1);

    guard_regs_t   r_d, r_q;
    logic          win_restart;
    logic          win_expire;
    logic [TW-1:0] win_limit;

    assign win_limit = (r_q.state == ST_OFF) ? TW'(OFF_TICKS) : TW'(ON_TICKS);

    stall_window #(
        .PRESCALE  (PRESCALE),
        .MAX_TICKS (MAX_TICKS)
    ) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (win_restart),
        .en      (active),
        .limit   (win_limit),
        .expire  (win_expire)
    );

    always_comb begin
        r_d                = r_q;
        r_d.release_strobe = 1'b0;
        win_restart        = 1'b0;
        if (!active) begin
            r_d.state   = ST_RUN;
            win_restart = 1'b1;
        end else begin
            unique case (r_q.state)
                ST_RUN: begin
                    if (fg_edge) begin
                        win_restart = 1'b1;
                    end else if (win_expire) begin
                        r_d.state   = ST_OFF;
                        win_restart = 1'b1;
                    end
                end
                ST_OFF: begin
                    if (win_expire) begin
                        r_d.state   = ST_TRY;
                        win_restart = 1'b1;
                    end
                end
                ST_TRY: begin
                    if (fg_edge) begin
                        r_d.state          = ST_RUN;
                        r_d.release_strobe = 1'b1;
                        win_restart        = 1'b1;
                    end else if (win_expire) begin
                        r_d.state   = ST_OFF;
                        win_restart = 1'b1;
                    end
                end
                default: begin
                    r_d.state   = ST_RUN;
                    win_restart = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state          <= ST_RUN;
            r_q.release_strobe <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign drive_inhibit = (r_q.state == ST_OFF);
    assign prot_active   = (r_q.state != ST_RUN);
    assign release_pulse = r_q.release_strobe;

    p_release_single_r6: assert property (
        @(posedge clk) disable iff (!rst_n) release_pulse |=> !release_pulse);

    p_release_after_try_r8: assert property (
        @(posedge clk) disable iff (!rst_n)
        release_pulse |-> (!prot_active && $past(r_q.state) == ST_TRY));

    p_inhibit_needs_prot_r8: assert property (
        @(posedge clk) disable iff (!rst_n) drive_inhibit |-> prot_active);

    p_standby_clears_r7: assert property (
        @(posedge clk) disable iff (!rst_n)
        !active |=> (!prot_active && !release_pulse));

    p_edge_keeps_run_r9: assert property (
        @(posedge clk) disable iff (!rst_n)
        (active && fg_edge && !prot_active) |=> !prot_active);

    p_run_holds_until_expiry_r2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (active && !prot_active && !win_expire) |=> !prot_active);

    p_rest_ignores_edges_r4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (active && drive_inhibit && !win_expire) |=> drive_inhibit);

endmodule

// File: tb/stall_guard_bench.sv
module stall_guard_bench;

    localparam int P   = 3;
    localparam int ON  = 4;
    localparam int OFF = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic active = 1'b0;
    logic fg_edge = 1'b0;
    logic drive_inhibit, prot_active, release_pulse;

    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 0;
    string ctx   = "R1";

    // Reference model: 0 = running, 1 = rest, 2 = retry
    int m_st = 0;
    int m_el = 0;
    bit m_rel = 0;

    always #4 clk = ~clk;

    stall_guard #(.PRESCALE(P), .ON_TICKS(ON), .OFF_TICKS(OFF)) u_stall_guard (
        .clk           (clk),
        .rst_n         (rst_n),
        .active        (active),
        .fg_edge       (fg_edge),
        .drive_inhibit (drive_inhibit),
        .prot_active   (prot_active),
        .release_pulse (release_pulse)
    );

    function automatic int win_len(int st);
        return ((st == 1) ? OFF : ON) * P;
    endfunction

    function automatic logic [2:0] exp_outs(int st, bit rel);
        return {st == 1, st != 0, rel};
    endfunction

    task automatic model_step(bit a, bit f);
        bit ex;
        if (!rst_n || !a) begin
            m_st = 0; m_el = 0; m_rel = 0;
            return;
        end
        ex    = (m_el == win_len(m_st) - 1);
        m_rel = 0;
        case (m_st)
            0: if (f) m_el = 0; else if (ex) begin m_st = 1; m_el = 0; end else m_el++;
            1: if (ex) begin m_st = 2; m_el = 0; end else m_el++;
            default: if (f) begin m_st = 0; m_el = 0; m_rel = 1; end
                     else if (ex) begin m_st = 1; m_el = 0; end else m_el++;
        endcase
    endtask

    task automatic compare();
        logic [2:0] got, want;
        got  = {drive_inhibit, prot_active, release_pulse};
        want = exp_outs(m_st, m_rel);
        n_chk++;
        if (got !== want) begin
            n_err++;
            $display("FAIL %s: inhibit/prot/release got %b expected %b at %0t",
                     ctx, got, want, $time);
        end
    endtask

    task automatic cyc(bit a, bit f);
        @(negedge clk);
        compare();
        active  = a;
        fg_edge = f;
        model_step(a, f);
    endtask

    task automatic run_idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0);
    endtask

    initial begin
        void'($urandom(32'h1F2E3D4C));

        ctx = "R1 reset";
        for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        run_idle(1);

        ctx = "R2 stall from activation";
        run_idle(P * ON + 3);

        ctx = "R4 rest window ignores edges";
        for (int i = 0; i < P * OFF + 2; i++) cyc(1'b1, (m_st == 1) && (i % 5 == 0));

        ctx = "R5 retry without rotation";
        while (m_st != 0 && !(m_st == 1 && m_el > 2)) cyc(1'b1, 1'b0);

        ctx = "R6 release on rotation";
        while (m_st != 2) cyc(1'b1, 1'b0);
        run_idle(2);
        cyc(1'b1, 1'b1);
        run_idle(3);

        ctx = "R3 edges restart timer";
        for (int i = 0; i < 120; i++) cyc(1'b1, (i % (P * ON - 1)) == 0);
        cyc(1'b1, 1'b1);
        run_idle(P * ON + 2);

        ctx = "R9 edge on expiry in running";
        cyc(1'b0, 1'b0);
        cyc(1'b1, 1'b1);
        while (m_el != P * ON - 1) cyc(1'b1, 1'b0);
        cyc(1'b1, 1'b1);
        run_idle(3);

        ctx = "R9 edge on expiry in retry";
        while (m_st != 2) cyc(1'b1, 1'b0);
        while (m_el != P * ON - 1) cyc(1'b1, 1'b0);
        cyc(1'b1, 1'b1);
        run_idle(3);

        ctx = "R7 stand-by clears protection";
        while (m_st != 1) cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b0);
        run_idle(P * ON + 2);
        while (m_st != 2) cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b1);
        run_idle(2);

        ctx = "R8 random mix";
        for (int ph = 0; ph < 40; ph++) begin
            int rate;
            case ($urandom_range(4))
                0: rate = 0;
                1: rate = 4;
                2: rate = 12;
                3: rate = 30;
                default: rate = 60;
            endcase
            for (int i = 0; i < 300; i++) begin
                bit a, f;
                a = ($urandom_range(199) != 0);
                f = (rate != 0) && ($urandom_range(rate - 1) == 0);
                cyc(a, f);
            end
        end
        cyc(1'b1, 1'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL R8 watchdog expired after 200000 cycles, expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule